// File: doc/BRIEF.md
# Multi-port receive DMA mover

This block drains received frame data from several per-port receive FIFOs into one shared frame buffer memory, 64 bits wide. Each clock cycle it grants a turn to one port with data waiting, chosen in round-robin order. The granted port gives up one 64-bit word. The block then writes that word into the port's current frame buffer. A word's address is formed from the buffer handle taken at the start of the frame and a word index within the buffer. The final word of a frame carries a byte-enable mask that covers only the bytes that were received.

When a frame ends with good status, the port raises a switch request. Pending switch requests are arbitrated round-robin and offered one at a time on a valid/ready interface. Each request carries the port number, the buffer handle and the first 64 bytes of the frame, which is the header area that holds both MAC addresses. A port whose request is still waiting gets no turns, so its header copy stays intact. A frame that ends with bad status raises no request, and its handle is returned on a one-cycle release output.

Top module: `rxdma_mover`

## Requirements
- R1: While reset is high, no port is popped, and the cycle after a reset edge shows mem_we, rel_valid and sreq_valid all low.
- R2: In each cycle at most one port is popped. Only ports with port_valid high and no waiting switch request are eligible. The grant goes to the first eligible port after the last granted port in cyclic index order, so idle ports are skipped.
- R3: The memory write appears on the clock edge that follows a pop. The address is {handle, word index}, with the handle in the upper HW bits and the word index in the lower OFFW bits. The word index is 0 for the first word of a frame and rises by one per word, which is 8 bytes.
- R4: A write of a word that is not the last in its frame has mem_be = 8'hFF. The last word (port_eof high) has its low port_nbytes bits set, for nbytes from 1 to 8. Byte k is held in data bits 8k+7:8k.
- R5: The handle on port_hdl is sampled on the first word of a frame, and hdl_take pulses for that port in the same cycle as that pop. Later words use the sampled handle, even if port_hdl changes.
- R6: One cycle after a good last word is written, sreq_valid rises with that port and handle. sreq_hdr word j (bits 64j+63:64j) holds frame word j, and bytes past the end of the frame read as zero.
- R7: A last word with port_good low raises no switch request. On the edge after its pop, rel_valid is high for one cycle and rel_handle carries the frame's handle.
- R8: While sreq_valid is high and sreq_ready is low, the port, the handle and the header all hold steady. The requesting port receives no turns until the request is accepted. Once accepted, sreq_valid falls on the next edge.
- R9: When several switch requests are waiting, they are offered in round-robin order, starting after the port that was offered last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_valid | input | NPORTS | Port FIFO holds a full word or a frame tail |
| port_data | input | NPORTS*64 | Head word of each port FIFO |
| port_eof | input | NPORTS | Head word is the last of its frame |
| port_nbytes | input | NPORTS*4 | Valid bytes in a last word (1 to 8) |
| port_good | input | NPORTS | Frame status, read with the last word |
| port_hdl | input | NPORTS*HW | Pre-reserved buffer handle for each port's next frame |
| port_pop | output | NPORTS | One-hot turn grant; pops the head word |
| hdl_take | output | NPORTS | Handle consumed (first word of a frame) |
| mem_we | output | 1 | Frame buffer write strobe |
| mem_addr | output | HW+OFFW | Frame buffer word address |
| mem_wdata | output | 64 | Frame buffer write data |
| mem_be | output | 8 | Byte enables for the write |
| rel_valid | output | 1 | Handle of a bad frame is returned |
| rel_handle | output | HW | Returned handle |
| sreq_valid | output | 1 | Switch request offered |
| sreq_ready | input | 1 | Lookup side accepts the request |
| sreq_port | output | clog2(NPORTS) | Requesting port |
| sreq_handle | output | HW | Buffer handle of the requesting frame |
| sreq_hdr | output | HDR_WORDS*64 | Leading frame bytes, word 0 in the low bits |

## Verification
The assertions rely on three assumptions about the inputs. A port's head word must not change unless that port is popped. port_nbytes must lie between 1 and 8 on last words. A frame must fit inside one buffer, so the word index never wraps. The bench holds every FIFO word steady until it sees the pop for it, sends only byte counts in that range, and sends frames of no more than three words. It drives inputs on the falling edge, so that the combinational grant and the registered results settle before they are sampled.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int WORD_BITS  = 64;
  localparam int WORD_BYTES = 8;

  // byte mask for a last word holding n valid bytes (low bytes first)
  function automatic logic [WORD_BYTES-1:0] tail_mask(input logic [3:0] n);
    logic [WORD_BYTES-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_BYTES; i++)
      if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  // widen a byte mask to a bit mask
  function automatic logic [WORD_BITS-1:0] bit_mask(input logic [WORD_BYTES-1:0] be);
    logic [WORD_BITS-1:0] m;
    for (int i = 0; i < WORD_BITS; i++) m[i] = be[i/8];
    return m;
  endfunction
endpackage

// File: rtl/rxdma_rr_arb.sv
module rxdma_rr_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] last_q;

  always_comb begin
    int c;
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int i = 1; i <= N; i++) begin
      c = int'(last_q) + i;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any      = 1'b1;
        gidx     = IW'(c);
        grant[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            last_q <= IW'(N-1);
    else if (adv && any) last_q <= gidx;
  end
endmodule

// File: rtl/rxdma_port_ctx.sv
module rxdma_port_ctx
  import rxdma_pkg::*;
#(
  parameter int HW        = 6,
  parameter int OFFW      = 8,
  parameter int HDR_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          take,
  input  logic [WORD_BITS-1:0]          data,
  input  logic [WORD_BYTES-1:0]         be,
  input  logic                          eof,
  input  logic                          good,
  input  logic [HW-1:0]                 hdl_in,
  input  logic                          clr_pend,
  output logic [HW-1:0]                 cur_hdl,
  output logic [HW-1:0]                 frame_hdl,
  output logic [OFFW-1:0]               cur_off,
  output logic                          first,
  output logic                          pending,
  output logic [HDR_WORDS*WORD_BITS-1:0] hdr_flat
);
  logic [OFFW-1:0]      off_q;
  logic [HW-1:0]        hdl_q;
  logic                 pend_q;
  logic [WORD_BITS-1:0] hdr_q [HDR_WORDS];
  logic [WORD_BITS-1:0] masked;

  assign first     = (off_q == '0);
  assign cur_hdl   = first ? hdl_in : hdl_q;
  assign frame_hdl = hdl_q;
  assign cur_off   = off_q;
  assign pending   = pend_q;
  assign masked    = data & bit_mask(be);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      hdl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (take) begin
        hdl_q <= cur_hdl;
        off_q <= eof ? '0 : off_q + 1'b1;
        if (eof && good) pend_q <= 1'b1;
      end
      if (clr_pend) pend_q <= 1'b0;
    end
  end

  // header copy: first word clears the rest so short frames read zero
  always_ff @(posedge clk) begin
    for (int j = 0; j < HDR_WORDS; j++) begin
      if (rst)
        hdr_q[j] <= '0;
      else if (take && first)
        hdr_q[j] <= (j == 0) ? masked : '0;
      else if (take && off_q == OFFW'(j))
        hdr_q[j] <= masked;
    end
  end

  for (genvar j = 0; j < HDR_WORDS; j++) begin : g_hdr
    assign hdr_flat[j*WORD_BITS +: WORD_BITS] = hdr_q[j];
  end
endmodule

// File: rtl/rxdma_mover.sv
module rxdma_mover
  import rxdma_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int HW        = 6,
  parameter int OFFW      = 8,
  parameter int HDR_WORDS = 8,
  localparam int PW       = $clog2(NPORTS),
  localparam int AW       = HW + OFFW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORTS-1:0]             port_valid,
  input  logic [NPORTS*64-1:0]          port_data,
  input  logic [NPORTS-1:0]             port_eof,
  input  logic [NPORTS*4-1:0]           port_nbytes,
  input  logic [NPORTS-1:0]             port_good,
  input  logic [NPORTS*HW-1:0]          port_hdl,
  output logic [NPORTS-1:0]             port_pop,
  output logic [NPORTS-1:0]             hdl_take,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [63:0]                   mem_wdata,
  output logic [7:0]                    mem_be,
  output logic                          rel_valid,
  output logic [HW-1:0]                 rel_handle,
  output logic                          sreq_valid,
  input  logic                          sreq_ready,
  output logic [PW-1:0]                 sreq_port,
  output logic [HW-1:0]                 sreq_handle,
  output logic [HDR_WORDS*64-1:0]       sreq_hdr
);
  localparam int HDRB = HDR_WORDS * WORD_BITS;

  logic [WORD_BITS-1:0]  data_a  [NPORTS];
  logic [WORD_BYTES-1:0] be_a    [NPORTS];
  logic [HW-1:0]         chdl_a  [NPORTS];
  logic [HW-1:0]         fhdl_a  [NPORTS];
  logic [OFFW-1:0]       off_a   [NPORTS];
  logic [HDRB-1:0]       hdr_a   [NPORTS];
  logic [NPORTS-1:0]     first_v, pend_v, clr_v;

  logic [NPORTS-1:0] turn_grant;
  logic [PW-1:0]     turn_idx;
  logic              turn_any;
  logic [NPORTS-1:0] sq_grant;
  logic [PW-1:0]     sq_idx;
  logic              sq_any;
  logic              sq_load;

  logic              sv_q;
  logic [PW-1:0]     sp_q;

  // ---------------- turn arbitration ----------------
  rxdma_rr_arb #(.N(NPORTS)) u_turn_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (port_valid & ~pend_v & ~{NPORTS{rst}}),
    .adv   (1'b1),
    .grant (turn_grant),
    .gidx  (turn_idx),
    .any   (turn_any)
  );

  assign port_pop = turn_grant;
  assign hdl_take = turn_grant & first_v;

  // ---------------- per-port context ----------------
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign data_a[p] = port_data[p*WORD_BITS +: WORD_BITS];
    assign be_a[p]   = port_eof[p] ? tail_mask(port_nbytes[p*4 +: 4]) : '1;
    assign clr_v[p]  = sv_q && sreq_ready && (sp_q == PW'(p));

    rxdma_port_ctx #(.HW(HW), .OFFW(OFFW), .HDR_WORDS(HDR_WORDS)) u_ctx (
      .clk       (clk),
      .rst       (rst),
      .take      (turn_grant[p]),
      .data      (data_a[p]),
      .be        (be_a[p]),
      .eof       (port_eof[p]),
      .good      (port_good[p]),
      .hdl_in    (port_hdl[p*HW +: HW]),
      .clr_pend  (clr_v[p]),
      .cur_hdl   (chdl_a[p]),
      .frame_hdl (fhdl_a[p]),
      .cur_off   (off_a[p]),
      .first     (first_v[p]),
      .pending   (pend_v[p]),
      .hdr_flat  (hdr_a[p])
    );
  end

  // ---------------- memory write stage ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      rel_valid  <= 1'b0;
      rel_handle <= '0;
    end else begin
      mem_we     <= turn_any;
      mem_addr   <= {chdl_a[turn_idx], off_a[turn_idx]};
      mem_wdata  <= data_a[turn_idx];
      mem_be     <= be_a[turn_idx];
      rel_valid  <= turn_any && port_eof[turn_idx] && !port_good[turn_idx];
      rel_handle <= chdl_a[turn_idx];
    end
  end

  // ---------------- switch-request arbitration ----------------
  assign sq_load = !sv_q && !rst;

  rxdma_rr_arb #(.N(NPORTS)) u_sreq_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (pend_v),
    .adv   (sq_load),
    .grant (sq_grant),
    .gidx  (sq_idx),
    .any   (sq_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q <= 1'b0;
      sp_q <= '0;
    end else if (sq_load && sq_any) begin
      sv_q <= 1'b1;
      sp_q <= sq_idx;
    end else if (sv_q && sreq_ready) begin
      sv_q <= 1'b0;
    end
  end

  assign sreq_valid  = sv_q;
  assign sreq_port   = sp_q;
  assign sreq_handle = fhdl_a[sp_q];
  assign sreq_hdr    = hdr_a[sp_q];

  logic unused_ok;
  assign unused_ok = ^sq_grant;
endmodule

// File: rtl/rxdma_mover_chk.sv
module rxdma_mover_chk #(
  parameter int NPORTS    = 4,
  parameter int HW        = 6,
  parameter int HDR_WORDS = 8,
  localparam int PW       = $clog2(NPORTS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPORTS-1:0]       port_valid,
  input logic [NPORTS-1:0]       port_pop,
  input logic [NPORTS-1:0]       hdl_take,
  input logic                    mem_we,
  input logic [7:0]              mem_be,
  input logic                    rel_valid,
  input logic                    sreq_valid,
  input logic                    sreq_ready,
  input logic [PW-1:0]           sreq_port,
  input logic [HW-1:0]           sreq_handle,
  input logic [HDR_WORDS*64-1:0] sreq_hdr
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mem_we && !rel_valid && !sreq_valid));

  p_one_turn_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_pop) && ((port_pop & ~port_valid) == '0));

  p_write_follows_turn_r3: assert property (@(posedge clk) disable iff (rst)
    (|port_pop) |=> mem_we);

  p_no_idle_write_r3: assert property (@(posedge clk) disable iff (rst)
    !(|port_pop) |=> !mem_we);

  p_be_shape_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be != 8'h00 && (mem_be & (mem_be + 8'd1)) == 8'h00));

  p_take_with_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (hdl_take & ~port_pop) == '0);

  p_release_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> mem_we);

  p_sreq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sreq_valid && !sreq_ready) |=>
      (sreq_valid && $stable(sreq_port) && $stable(sreq_handle) && $stable(sreq_hdr)));

  p_stall_pending_r8: assert property (@(posedge clk) disable iff (rst)
    sreq_valid |-> !port_pop[sreq_port]);
endmodule

bind rxdma_mover rxdma_mover_chk #(.NPORTS(NPORTS), .HW(HW), .HDR_WORDS(HDR_WORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .port_valid (port_valid),
  .port_pop   (port_pop),
  .hdl_take   (hdl_take),
  .mem_we     (mem_we),
  .mem_be     (mem_be),
  .rel_valid  (rel_valid),
  .sreq_valid (sreq_valid),
  .sreq_ready (sreq_ready),
  .sreq_port  (sreq_port),
  .sreq_handle(sreq_handle),
  .sreq_hdr   (sreq_hdr)
);

// File: tb/test_rxdma_mover.sv
module test_rxdma_mover;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int HW   = 6;
  localparam int OFFW = 8;
  localparam int HDRW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N-1:0]      port_valid = '0;
  logic [N*64-1:0]   port_data = '0;
  logic [N-1:0]      port_eof = '0;
  logic [N*4-1:0]    port_nbytes = '0;
  logic [N-1:0]      port_good = '0;
  logic [N*HW-1:0]   port_hdl = '0;
  logic [N-1:0]      port_pop, hdl_take;
  logic              mem_we;
  logic [HW+OFFW-1:0] mem_addr;
  logic [63:0]       mem_wdata;
  logic [7:0]        mem_be;
  logic              rel_valid;
  logic [HW-1:0]     rel_handle;
  logic              sreq_valid;
  logic              sreq_ready = 1'b0;
  logic [1:0]        sreq_port;
  logic [HW-1:0]     sreq_handle;
  logic [HDRW*64-1:0] sreq_hdr;

  int nchecks = 0;
  int nerrs   = 0;
  int last_turn;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_mover #(.NPORTS(N), .HW(HW), .OFFW(OFFW), .HDR_WORDS(HDRW)) i_rxdma_mover (
    .clk(clk), .rst(rst), .port_valid(port_valid), .port_data(port_data),
    .port_eof(port_eof), .port_nbytes(port_nbytes), .port_good(port_good),
    .port_hdl(port_hdl), .port_pop(port_pop), .hdl_take(hdl_take),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .rel_valid(rel_valid), .rel_handle(rel_handle), .sreq_valid(sreq_valid),
    .sreq_ready(sreq_ready), .sreq_port(sreq_port), .sreq_handle(sreq_handle),
    .sreq_hdr(sreq_hdr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic v, input logic [63:0] d,
                       input logic e, input logic [3:0] nb, input logic g);
    port_valid[p] = v;
    port_data[p*64 +: 64] = d;
    port_eof[p] = e;
    port_nbytes[p*4 +: 4] = nb;
    port_good[p] = g;
  endtask

  task automatic idle_all();
    for (int p = 0; p < N; p++) drive(p, 1'b0, 64'h0, 1'b0, 4'd8, 1'b0);
  endtask

  function automatic logic [HW+OFFW-1:0] addr_of(input int h, input int off);
    return {HW'(h), OFFW'(off)};
  endfunction

  // R1: reset behaviour
  task automatic t_reset();
    rst = 1'b1;
    port_valid = '1;
    @(negedge clk); #1;
    chk("R1 pop in reset", 64'(port_pop), 64'h0);
    @(posedge clk); #1;
    chk("R1 mem_we in reset", 64'(mem_we), 64'h0);
    chk("R1 sreq_valid in reset", 64'(sreq_valid), 64'h0);
    chk("R1 rel_valid in reset", 64'(rel_valid), 64'h0);
    @(negedge clk);
    idle_all();
    rst = 1'b0;
    last_turn = N-1;
  endtask

  // R3 R4 R5 R6 R8: one good frame on port 1, then a held request
  task automatic t_single();
    logic [63:0] w [3];
    w[0] = 64'h0807060504030201;
    w[1] = 64'h1817161514131211;
    w[2] = 64'h2827262524232221;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive(1, 1'b1, w[k], k == 2, 4'd5, 1'b1);
      port_hdl[1*HW +: HW] = (k == 0) ? HW'(9) : HW'(33);
      #1;
      chk("R2 pop port1", 64'(port_pop), 64'h2);
      chk("R5 hdl_take", 64'(hdl_take), (k == 0) ? 64'h2 : 64'h0);
      @(posedge clk); #1;
      chk("R3 write strobe", 64'(mem_we), 64'h1);
      chk("R3 address", 64'(mem_addr), 64'(addr_of(9, k)));
      chk("R3 write data", mem_wdata, w[k]);
      chk("R4 byte enables", 64'(mem_be), (k == 2) ? 64'h1F : 64'hFF);
    end
    last_turn = 1;
    @(negedge clk);
    idle_all();
    @(posedge clk); #1;
    chk("R6 sreq_valid", 64'(sreq_valid), 64'h1);
    chk("R6 sreq_port", 64'(sreq_port), 64'h1);
    chk("R6 sreq_handle", 64'(sreq_handle), 64'd9);
    chk("R6 header word0", sreq_hdr[0 +: 64], w[0]);
    chk("R6 header word1", sreq_hdr[64 +: 64], w[1]);
    chk("R6 header word2 masked", sreq_hdr[128 +: 64], 64'h0000002524232221);
    chk("R6 header tail zero", 64'(|sreq_hdr[HDRW*64-1:192]), 64'h0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      drive(1, 1'b1, 64'hDEAD, 1'b1, 4'd8, 1'b1);
      #1;
      chk("R8 stalled port not popped", 64'(port_pop), 64'h0);
      @(posedge clk); #1;
      chk("R8 request held", 64'(sreq_valid), 64'h1);
      chk("R8 handle held", 64'(sreq_handle), 64'd9);
    end
    @(negedge clk);
    idle_all();
    sreq_ready = 1'b1;
    @(posedge clk); #1;
    chk("R8 request drops after accept", 64'(sreq_valid), 64'h0);
    @(negedge clk);
    sreq_ready = 1'b0;
  endtask

  // R7: bad frame releases its handle
  task automatic t_bad();
    @(negedge clk);
    drive(0, 1'b1, 64'hCAFE, 1'b1, 4'd8, 1'b0);
    port_hdl[0 +: HW] = HW'(5);
    #1;
    chk("R7 pop port0", 64'(port_pop), 64'h1);
    @(posedge clk); #1;
    chk("R7 rel_valid", 64'(rel_valid), 64'h1);
    chk("R7 rel_handle", 64'(rel_handle), 64'd5);
    chk("R4 full last word", 64'(mem_be), 64'hFF);
    last_turn = 0;
    @(negedge clk);
    idle_all();
    @(posedge clk); #1;
    chk("R7 release is one cycle", 64'(rel_valid), 64'h0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      chk("R7 no switch request", 64'(sreq_valid), 64'h0);
    end
  endtask

  // R2 R3: interleaved turns over ports 0, 2, 3 (port 1 idle, skipped)
  task automatic t_rr();
    int cnt [N];
    int hdl [N];
    int done = 0;
    for (int p = 0; p < N; p++) begin
      cnt[p] = (p == 1) ? 3 : 0;
      hdl[p] = 10 + p;
      port_hdl[p*HW +: HW] = HW'(hdl[p]);
    end
    for (int it = 0; it < 20 && done < 9; it++) begin
      int e;
      @(negedge clk);
      for (int p = 0; p < N; p++)
        drive(p, cnt[p] < 3, {32'(p), 32'(cnt[p])}, cnt[p] == 2, 4'd8, 1'b0);
      #1;
      e = -1;
      for (int i = 1; i <= N; i++) begin
        int c;
        c = (last_turn + i) % N;
        if (e < 0 && cnt[c] < 3) e = c;
      end
      chk("R2 round-robin turn", 64'(port_pop), 64'(1 << e));
      last_turn = e;
      @(posedge clk); #1;
      chk("R3 per-port address", 64'(mem_addr), 64'(addr_of(hdl[e], cnt[e])));
      chk("R7 release on bad tail", 64'(rel_valid), 64'(cnt[e] == 2));
      cnt[e]++;
      done++;
    end
    chk("R2 all words moved", 64'(done), 64'd9);
    @(negedge clk);
    idle_all();
  endtask

  // R9: round-robin among pending switch requests
  task automatic t_sreq_rr();
    logic [N-1:0] sent;
    int got [3];
    int ng = 0;
    sreq_ready = 1'b0;
    port_hdl[2*HW +: HW] = HW'(20);
    @(negedge clk);
    drive(2, 1'b1, 64'h22, 1'b1, 4'd1, 1'b1);
    @(negedge clk);
    idle_all();
    @(posedge clk); #1;
    chk("R9 first request port2", 64'(sreq_port), 64'd2);
    chk("R6 handle port2", 64'(sreq_handle), 64'd20);
    port_hdl[0 +: HW] = HW'(21);
    port_hdl[3*HW +: HW] = HW'(23);
    sent = '0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      drive(0, !sent[0], 64'h00, 1'b1, 4'd8, 1'b1);
      drive(3, !sent[3], 64'h33, 1'b1, 4'd8, 1'b1);
      #1;
      sent = sent | port_pop;
    end
    @(negedge clk);
    idle_all();
    chk("R9 both frames stored", 64'(sent), 64'h9);
    @(negedge clk);
    sreq_ready = 1'b1;
    for (int c = 0; c < 12 && ng < 3; c++) begin
      #1;
      if (sreq_valid) begin
        got[ng] = int'(sreq_port);
        ng++;
      end
      @(negedge clk);
    end
    sreq_ready = 1'b0;
    chk("R9 request count", 64'(ng), 64'd3);
    chk("R9 order first", 64'(got[0]), 64'd2);
    chk("R9 order second", 64'(got[1]), 64'd3);
    chk("R9 order third", 64'(got[2]), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nerrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    idle_all();
    t_reset();
    t_single();
    t_bad();
    t_rr();
    t_sreq_rr();
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule